// File: doc/BRIEF.md
# Quasi-Resonant Valley Switching Timer

This block produces the gate drive for the main switch of a quasi-resonant flyback converter. All of its inputs are single-bit results of comparators outside the block: the level of the delayed auxiliary-winding signal against the zero-crossing threshold, the same signal against a ringing threshold, a trip that fires when the sensed current exceeds the feedback level, and a trip for the absolute peak current limit. A separate load-tracking counter supplies the valley number, which is how many ringing valleys to wait for before the next turn-on.

While the gate is low, the block counts falling edges of the zero-crossing bit and holds off turn-on for a suppression window. The window is short when the ringing is large and long when it is small. Once the window has passed, the gate turns on as soon as the count reaches the valley number. If no such turn-on happens, it turns on when a maximum off time runs out. While the gate is high, both current trips are masked for a blanking interval. After that, either trip turns the gate off, and a maximum on time forces it off if neither trip arrives. A low enable forces the gate low and restarts every counter and timer.

All times are parameters counted in clock cycles. An off-phase cycle index j counts from 0 in the first cycle the gate is low, and an on-phase index counts the same way from the first cycle the gate is high. A decision taken in cycle j shows on `gate` after the next rising clock edge, so the phase lasts j+1 cycles.

Top module: `qr_valley_timer`

## Requirements
- R1: While `gate` is low, each 1-to-0 transition of `zc_det` between two consecutive cycles adds one to the valley count. The count saturates at ZC_MAX (7): further transitions leave it at 7 and never wrap it back.
- R2: The valley count is 0 from the first high cycle of `gate` onward. Transitions of `zc_det` while `gate` is high are not counted toward the next off phase.
- R3: After `gate` falls, it stays low for at least SUP_SHORT cycles.
- R4: In off-phase cycle j, turn-on is allowed only if j >= SUP_LONG-1, or if `ring_hi` is 1 in that cycle and j >= SUP_SHORT-1.
- R5: When turn-on is allowed, `gate` rises after the first cycle in which the registered valley count is >= `valley_req`. A transition seen in cycle i is counted from cycle i+1, so the gate can be high at the earliest from cycle i+2.
- R6: If neither R5 condition is met earlier, `gate` rises after off-phase cycle OFF_MAX-1, so the off time is exactly OFF_MAX cycles, whatever the counts or `ring_hi`.
- R7: Trips in on-phase cycles 0 to LEB-2 are ignored, so `gate` stays high for at least LEB cycles.
- R8: A `cs_trip` seen in on-phase cycle j >= LEB-1 makes that cycle the last high cycle.
- R9: An `ilim_trip` ends the on phase in the same way. Whichever of the two trips is first seen after blanking ends the pulse.
- R10: If no trip ends it earlier, the on phase ends after cycle ON_MAX-1, so the pulse is exactly ON_MAX cycles.
- R11: While `en` is 0, `gate` is 0 from the next clock edge and the valley count and timers are cleared. When `en` returns to 1, a fresh off phase starts at cycle index 0 with suppression applied.
- R12: During and after reset, `gate` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | 1 runs the block; 0 forces the gate low and clears all state |
| zc_det | input | 1 | Zero-crossing comparator; 1 means the signal is above the threshold |
| ring_hi | input | 1 | Ringing-level comparator; 1 selects the short suppression window |
| cs_trip | input | 1 | Sensed current has exceeded the feedback level |
| ilim_trip | input | 1 | Peak current limit has been reached |
| valley_req | input | $clog2(ZC_MAX+1) | Number of valleys to wait for; 0 means turn on at the end of suppression |
| gate | output | 1 | Gate drive for the main switch |

## Verification
Two pairs of functions can fire in the same cycle. In the off phase, the last valley can arrive in the very cycle the maximum off time runs out. The bench places a single falling edge two cycles before that limit and expects one rise after exactly OFF_MAX low cycles. In the on phase, the bench first asserts the current trip in on-phase cycle ON_MAX-1, the same cycle the maximum on time expires, and expects one clean fall after exactly ON_MAX high cycles. In both cases the pulse lengths are compared with a per-cycle model that the bench builds from the requirements.

// File: rtl/qrv_pkg.sv
package qrv_pkg;

   // Phase of the switching cycle; the encoding equals the gate level.
   typedef enum logic {
      PH_OFF = 1'b0,
      PH_ON  = 1'b1
   } qrv_phase_e;

endpackage

// File: rtl/qrv_phase_timer.sv
// Cycle counter for one switching phase. It restarts at zero while clr
// is high and otherwise counts up, stopping at LIMIT.
module qrv_phase_timer #(
   parameter int LIMIT = 100,
   parameter int W     = $clog2(LIMIT + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] cnt
);

   localparam logic [W-1:0] LIM_V = W'(LIMIT);

   generate
      if (LIMIT < 1) begin : g_bad_limit
         $error("qrv_phase_timer: LIMIT must be at least 1");
      end
      if ((2 ** W) <= LIMIT) begin : g_bad_width
         $error("qrv_phase_timer: W too narrow for LIMIT");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (cnt != LIM_V) begin
         cnt <= cnt + 1'b1;
      end
   end

   // The count never runs past its limit.
   a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LIM_V);

endmodule

// File: rtl/qrv_valley_cnt.sv
// Counts falling edges of the zero-crossing bit while armed, saturating
// at ZC_MAX. It clears on request.
module qrv_valley_cnt #(
   parameter int ZC_MAX = 7,
   parameter int CW     = $clog2(ZC_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          arm,
   input  logic          zc_det,
   output logic [CW-1:0] cnt
);

   localparam logic [CW-1:0] MAX_V = CW'(ZC_MAX);

   logic zc_prev;
   logic fall;
   logic at_max;

   generate
      if (ZC_MAX < 1) begin : g_bad_max
         $error("qrv_valley_cnt: ZC_MAX must be at least 1");
      end
      // With a full-range width the top value is all ones; otherwise compare.
      if (ZC_MAX == (2 ** CW) - 1) begin : g_full_range
         assign at_max = &cnt;
      end else begin : g_part_range
         assign at_max = (cnt == MAX_V);
      end
   endgenerate

   assign fall = zc_prev & ~zc_det;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         zc_prev <= 1'b0;
      end else begin
         zc_prev <= zc_det;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (clr) begin
         cnt <= '0;
      end else if (arm && fall && !at_max) begin
         cnt <= cnt + 1'b1;
      end
   end

   // R1: the count stays within its range
   a_r1_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= MAX_V);

   // R1: without an armed falling edge the count holds
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !(arm && fall)) |=> $stable(cnt));

   // R2: a clear request empties the count by the next cycle
   a_r2_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));

endmodule

// File: rtl/qr_valley_timer.sv
module qr_valley_timer #(
   parameter int ZC_MAX    = 7,
   parameter int SUP_SHORT = 312,
   parameter int SUP_LONG  = 3125,
   parameter int OFF_MAX   = 5250,
   parameter int LEB       = 41,
   parameter int ON_MAX    = 3750
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         en,
   input  logic                         zc_det,
   input  logic                         ring_hi,
   input  logic                         cs_trip,
   input  logic                         ilim_trip,
   input  logic [$clog2(ZC_MAX+1)-1:0]  valley_req,
   output logic                         gate
);
   import qrv_pkg::*;

   localparam int ZW  = $clog2(ZC_MAX + 1);
   localparam int OFW = $clog2(OFF_MAX);
   localparam int ONW = $clog2(ON_MAX);

   localparam logic [OFW-1:0] SS_LIM  = OFW'(SUP_SHORT - 1);
   localparam logic [OFW-1:0] SL_LIM  = OFW'(SUP_LONG - 1);
   localparam logic [OFW-1:0] OFF_LIM = OFW'(OFF_MAX - 1);
   localparam logic [ONW-1:0] LEB_LIM = ONW'(LEB - 1);
   localparam logic [ONW-1:0] ON_LIM  = ONW'(ON_MAX - 1);

   generate
      if (SUP_SHORT < 2) begin : g_bad_short
         $error("qr_valley_timer: SUP_SHORT must be at least 2");
      end
      if (SUP_LONG < SUP_SHORT) begin : g_bad_long
         $error("qr_valley_timer: SUP_LONG must not be below SUP_SHORT");
      end
      if (OFF_MAX <= SUP_LONG) begin : g_bad_off
         $error("qr_valley_timer: OFF_MAX must exceed SUP_LONG");
      end
      if (LEB < 2) begin : g_bad_leb
         $error("qr_valley_timer: LEB must be at least 2");
      end
      if (ON_MAX <= LEB) begin : g_bad_on
         $error("qr_valley_timer: ON_MAX must exceed LEB");
      end
   endgenerate

   qrv_phase_e     phase_q;
   qrv_phase_e     phase_d;
   logic           gate_hi;
   logic [ZW-1:0]  zc_cnt;
   logic [OFW-1:0] off_cnt;
   logic [ONW-1:0] on_cnt;
   logic           sup_done;
   logic           valley_ok;
   logic           off_expire;
   logic           turn_on;
   logic           blank_done;
   logic           on_expire;
   logic           turn_off;
   logic           zc_clr;
   logic           off_clr;
   logic           on_clr;

   assign gate_hi = (phase_q == PH_ON);
   assign gate    = gate_hi;

   // ---------------- off phase: valleys, suppression, timeout ----------
   assign zc_clr  = ~en | gate_hi | turn_on;
   assign off_clr = ~en | gate_hi;

   qrv_valley_cnt #(
      .ZC_MAX (ZC_MAX),
      .CW     (ZW)
   ) valley_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (zc_clr),
      .arm    (~gate_hi),
      .zc_det (zc_det),
      .cnt    (zc_cnt)
   );

   qrv_phase_timer #(
      .LIMIT (OFF_MAX - 1),
      .W     (OFW)
   ) off_tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (off_clr),
      .cnt   (off_cnt)
   );

   assign sup_done   = (off_cnt >= SL_LIM) | (ring_hi & (off_cnt >= SS_LIM));
   assign valley_ok  = (zc_cnt >= valley_req);
   assign off_expire = (off_cnt == OFF_LIM);
   assign turn_on    = ~gate_hi & ((sup_done & valley_ok) | off_expire);

   // ---------------- on phase: blanking, trips, timeout ----------------
   assign on_clr = ~en | ~gate_hi;

   qrv_phase_timer #(
      .LIMIT (ON_MAX - 1),
      .W     (ONW)
   ) on_tmr_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (on_clr),
      .cnt   (on_cnt)
   );

   assign blank_done = (on_cnt >= LEB_LIM);
   assign on_expire  = (on_cnt == ON_LIM);
   assign turn_off   = gate_hi & ((blank_done & (cs_trip | ilim_trip)) | on_expire);

   // ---------------- gate state ---------------------------------------
   always_comb begin
      phase_d = phase_q;
      if (!en) begin
         phase_d = PH_OFF;
      end else if (gate_hi) begin
         if (turn_off) phase_d = PH_OFF;
      end else begin
         if (turn_on) phase_d = PH_ON;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_OFF;
      end else begin
         phase_q <= phase_d;
      end
   end

   // R3: no rise inside the short window
   a_r3_min_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_hi && off_cnt < SS_LIM) |=> !gate_hi);

   // R4: without ringing level the long window holds the gate low
   a_r4_long_window: assert property (@(posedge clk) disable iff (!rst_n)
      (!gate_hi && !ring_hi && off_cnt < SL_LIM) |=> !gate_hi);

   // R5: every rise is backed by enough valleys or by the timeout
   a_r5_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(gate_hi) |-> ($past(zc_cnt) >= $past(valley_req) ||
                          $past(off_cnt) == OFF_LIM));

   // R6: the off-time limit always turns the gate on
   a_r6_max_off: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !gate_hi && off_cnt == OFF_LIM) |=> gate_hi);

   // R7: trips cannot end the pulse inside blanking
   a_r7_blank: assert property (@(posedge clk) disable iff (!rst_n)
      (en && gate_hi && on_cnt < LEB_LIM) |=> gate_hi);

   // R10: the on-time limit always turns the gate off
   a_r10_max_on: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_hi && on_cnt == ON_LIM) |=> !gate_hi);

   // R11: a low enable forces the gate low at the next edge
   a_r11_disable: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !gate_hi);

endmodule

// File: tb/qr_valley_timer_tb.sv
`timescale 1ns/1ps
module qr_valley_timer_tb_top;

   localparam int ZCM = 7;
   localparam int SS  = 20;
   localparam int SL  = 60;
   localparam int OM  = 100;
   localparam int LB  = 5;
   localparam int ONM = 80;
   localparam int NONE = 100000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       en = 1'b0;
   logic       zc_det = 1'b0;
   logic       ring_hi = 1'b0;
   logic       cs_trip = 1'b0;
   logic       ilim_trip = 1'b0;
   logic [2:0] valley_req = 3'd0;
   logic       gate;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   qr_valley_timer #(
      .ZC_MAX (ZCM), .SUP_SHORT (SS), .SUP_LONG (SL),
      .OFF_MAX (OM), .LEB (LB), .ON_MAX (ONM)
   ) dut_i (
      .clk (clk), .rst_n (rst_n), .en (en), .zc_det (zc_det),
      .ring_hi (ring_hi), .cs_trip (cs_trip), .ilim_trip (ilim_trip),
      .valley_req (valley_req), .gate (gate)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected off length from the requirements (R1, R4, R5, R6).
   function automatic int exp_low(input bit [0:255] zs, input bit [0:255] rs, input int vreq);
      int cnt = 0;
      for (int j = 0; j < 256; j++) begin
         bit pz = (j == 0) ? 1'b0 : zs[j-1];
         int sup = rs[j] ? SS : SL;
         if (j == OM - 1 || (j >= sup - 1 && cnt >= vreq)) return j + 1;
         if (pz && !zs[j] && cnt < ZCM) cnt++;
      end
      return -1;
   endfunction

   // Expected on length from the requirements (R7 to R10).
   function automatic int exp_high(input int cs_at, input int il_at);
      for (int j = 0; j < 256; j++) begin
         bit trip = (j >= cs_at) || (j >= il_at);
         if (j == ONM - 1 || (j >= LB - 1 && trip)) return j + 1;
      end
      return -1;
   endfunction

   // Called at the falling edge that opens off-phase cycle 0.
   task automatic run_off(input bit [0:255] zs, input bit [0:255] rs, input int vreq, output int k);
      k = 0;
      valley_req = vreq[2:0];
      while (1) begin
         zc_det  = zs[k];
         ring_hi = rs[k];
         @(posedge clk); @(negedge clk);
         k++;
         if (gate || k > 250) break;
      end
      zc_det = 1'b0;
   endtask

   // Called at the falling edge that opens on-phase cycle 0.
   task automatic run_on(input int cs_at, input int il_at, input bit tog, output int k);
      k = 0;
      while (1) begin
         cs_trip   = (k >= cs_at);
         ilim_trip = (k >= il_at);
         zc_det    = (tog && k < 8) ? k[0] : 1'b0;
         @(posedge clk); @(negedge clk);
         k++;
         if (!gate || k > 250) break;
      end
      cs_trip = 1'b0; ilim_trip = 1'b0; zc_det = 1'b0;
   endtask

   task automatic fresh();
      @(negedge clk); en = 1'b0; zc_det = 1'b0; cs_trip = 1'b0; ilim_trip = 1'b0;
      repeat (2) @(negedge clk);
      en = 1'b1;
   endtask

   task automatic off_check(input bit [0:255] zs, input bit [0:255] rs, input int vreq, input string req);
      int k;
      int e = exp_low(zs, rs, vreq);
      run_off(zs, rs, vreq, k);
      check(k == e, req, k, e);
   endtask

   task automatic on_check(input int cs_at, input int il_at, input string req);
      int k;
      int e = exp_high(cs_at, il_at);
      run_on(cs_at, il_at, 1'b0, k);
      check(k == e, req, k, e);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; en = 1'b1;
      repeat (3) @(negedge clk);
      check(gate == 1'b0, "R12 in reset", gate, 0);
      en = 1'b0;
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check(gate == 1'b0, "R12 after reset", gate, 0);
   endtask

   task automatic t_suppression();
      bit [0:255] z = '0;
      bit [0:255] r = '1;
      fresh(); off_check(z, r, 0, "R4 R3 short window");
      r = '0;
      fresh(); off_check(z, r, 0, "R4 long window");
      r = '0; r[30:255] = '1;
      fresh(); off_check(z, r, 0, "R4 ring level rises late");
   endtask

   task automatic t_valleys();
      bit [0:255] z = '0;
      bit [0:255] r = '1;
      z[1] = 1; z[3] = 1; z[5] = 1;
      fresh(); off_check(z, r, 3, "R5 valleys before window end");
      z = '0; z[25] = 1; z[29] = 1; z[33] = 1;
      fresh(); off_check(z, r, 3, "R5 R1 third valley after window");
      z = '0; r = '0;
      for (int i = 0; i < 9; i++) z[2 + 3 * i] = 1;
      fresh(); off_check(z, r, 7, "R1 saturation at seven");
      z = '0; r = '1;
      for (int i = 0; i < 5; i++) z[2 + 3 * i] = 1;
      fresh(); off_check(z, r, 6, "R6 too few valleys");
      z = '0; z[OM - 3] = 1;
      fresh(); off_check(z, r, 1, "R6 R5 valley meets timeout");
   endtask

   task automatic t_on_phase();
      bit [0:255] z = '0;
      bit [0:255] r = '1;
      fresh(); off_check(z, r, 0, "R4 lead-in");
      on_check(0, NONE, "R7 trip inside blanking");
      off_check(z, r, 0, "R4 between pulses");
      on_check(10, NONE, "R8 current over feedback");
      off_check(z, r, 0, "R4 between pulses");
      on_check(30, 12, "R9 peak limit first");
      off_check(z, r, 0, "R4 between pulses");
      on_check(9, 20, "R9 feedback trip first");
      off_check(z, r, 0, "R4 between pulses");
      on_check(NONE, NONE, "R10 no trip");
      off_check(z, r, 0, "R4 between pulses");
      on_check(ONM - 1, NONE, "R10 R8 trip meets timeout");
   endtask

   task automatic t_clear();
      bit [0:255] z = '0;
      bit [0:255] r = '1;
      int k;
      z[1] = 1; z[3] = 1;
      fresh(); off_check(z, r, 2, "R5 two valleys");
      on_check(10, NONE, "R8 pulse");
      z = '0;
      run_off(z, r, 1, k);
      check(k == OM, "R2 count cleared at turn-on", k, OM);
      run_on(20, NONE, 1'b1, k);
      check(k == 21, "R8 pulse with ringing", k, 21);
      run_off(z, r, 1, k);
      check(k == OM, "R2 edges while high ignored", k, OM);
   endtask

   task automatic t_enable();
      bit [0:255] z = '0;
      bit [0:255] r = '1;
      int k;
      fresh(); off_check(z, r, 0, "R4 lead-in");
      repeat (3) @(negedge clk);
      check(gate == 1'b1, "R11 pulse running", gate, 1);
      en = 1'b0;
      @(negedge clk);
      check(gate == 1'b0, "R11 gate low after enable drop", gate, 0);
      for (int i = 0; i < 4; i++) begin
         zc_det = i[0];
         @(negedge clk);
      end
      zc_det = 1'b0;
      @(negedge clk);
      check(gate == 1'b0, "R11 held low while disabled", gate, 0);
      en = 1'b1;
      run_off(z, r, 1, k);
      check(k == OM, "R11 count cleared while disabled", k, OM);
      on_check(10, NONE, "R8 pulse");
      en = 1'b0;
      @(negedge clk); @(negedge clk);
      en = 1'b1;
      run_off(z, r, 0, k);
      check(k == SS, "R11 suppression restarts", k, SS);
   endtask

   initial begin
      t_reset();
      t_suppression();
      t_valleys();
      t_on_phase();
      t_clear();
      t_enable();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule